// File: doc/BRIEF.md
# Synchronization Cell Window Decoder

This block sits in front of a bank of inter-thread synchronization cells (FIFO cells followed by semaphore cells). It holds two 64-bit address-map words that place a storage window in the 32-bit address space. From these words it derives the window base, the window size and an enable. Every access on the storage side is decoded by this block. It checks that the access falls inside the window. It extracts the view code and the cell index, with the cell stride set by a grain field. It rejects accesses narrower than four bytes with a bus-error strobe and a sticky error flag.

View codes 0 to 5 are forwarded to the addressed cell, and the block passes the cell's read data back. View 15 reaches a status/control word that lives inside the block. All other view codes are inert. All outputs on the access side are combinational in the access cycle. State changes take effect at the next clock edge. An access completes in its own cycle unless the addressed cell asks for a stall.

Top module: `sync_window_decoder`

## Requirements
- R1: After reset, map word 0 reads 0. Map word 1 reads 0xC00 OR'd with (NCELL << 20), where NCELL = NFIFO + NSEM. The window size is 4096, the window is disabled, and the status word reads NCELL << 16.
- R2: A write to map word 0 (index 0) keeps only bits 31:10 (base) and bit 0 (enable). A write to map word 1 (index 1) keeps only bits 16:10 (mask) and bits 2:0 (grain). All other bits read back unchanged by the write, and the cell count at bit 20 cannot be written.
- R3: A map read at index 2 or above returns 0. A map write at index 2 or above changes nothing.
- R4: One cycle after a write to word 0, win_base equals word 0 bits 31:10 followed by ten zero bits, and win_en equals word 0 bit 0.
- R5: The candidate window size is 1024 plus (mask field × 1024). After a map write, the candidate replaces win_size only when it is a power of two; otherwise win_size keeps its old value.
- R6: An access hits only when the window is enabled and base ≤ address < base + size. A miss raises neither cell_req nor acc_err.
- R7: For a hit, view equals offset bits 6:3, where offset = address − base. The cell index is offset >> (7 + grain). An index of NCELL or above selects cell NCELL−1.
- R8: A hit with acc_size code 0 (1 byte) or 1 (2 bytes) pulses acc_err, raises no cell_req and returns 0. Status bit 2 reads 1 from the next cycle on.
- R9: A full-width hit with view 15 reads the status word: count at bit 16, grain at bits 10:8, sticky access error at bit 2. A full-width write with view 15 clears bit 2 when data bit 2 is 1 and replaces bits 10:8 with data bits 10:8.
- R10: A full-width hit with views 6 to 14 reads all ones, raises no cell_req and leaves the status word unchanged.
- R11: A full-width hit with views 0 to 5 raises cell_req with cell_wr = acc_wr and returns cell_rdata. While cell_stall is high, acc_done stays low; otherwise every access sees acc_done high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Map word write strobe |
| cfg_idx | input | 3 | Map word index (byte offset / 8) |
| cfg_wdata | input | 64 | Map word write data |
| cfg_rdata | output | 64 | Map word read data (combinational) |
| win_base | output | 32 | Applied window base |
| win_size | output | 18 | Applied window size in bytes |
| win_en | output | 1 | Window enable |
| acc_valid | input | 1 | Storage access present |
| acc_wr | input | 1 | Storage access is a write |
| acc_size | input | 2 | Access width code: 0=1B, 1=2B, 2=4B, 3=8B |
| acc_addr | input | 32 | Storage access address |
| acc_wdata | input | 64 | Storage write data |
| acc_rdata | output | 64 | Storage read data |
| acc_hit | output | 1 | Access falls inside the enabled window |
| acc_err | output | 1 | Bus-error strobe for sub-word access |
| acc_done | output | 1 | Access completes this cycle |
| cell_req | output | 1 | Request to the selected cell |
| cell_wr | output | 1 | Cell request is a write |
| cell_sel | output | CELL_W | Selected cell index |
| cell_view | output | 4 | View code for the cell |
| cell_wdata | output | 64 | Write data to the cell |
| cell_rdata | input | 64 | Read data from the selected cell |
| cell_stall | input | 1 | Selected cell is not ready |

## Verification
The bench targets four kinds of corner case. It writes mask values that give a non-power-of-two size; a design that applied them would shrink or grow the window and move the hit boundary. It probes addresses one byte below the window, one byte past its end and at both edges; an off-by-one compare would then decode a foreign address or drop the last byte. It uses large offsets with every grain setting; a design that wrapped the cell index instead of clamping it would select a low cell in place of the last one. It mixes sub-word accesses with status writes; if the sticky flag were lost, or set by a full-width access, the status read-back would disagree with the bench's model.

// File: rtl/sync_window_decoder.sv
module sync_window_decoder #(
  parameter int NFIFO = 16,
  parameter int NSEM  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [2:0]        cfg_idx,
  input  logic [63:0]       cfg_wdata,
  output logic [63:0]       cfg_rdata,
  output logic [31:0]       win_base,
  output logic [17:0]       win_size,
  output logic              win_en,
  input  logic              acc_valid,
  input  logic              acc_wr,
  input  logic [1:0]        acc_size,
  input  logic [31:0]       acc_addr,
  input  logic [63:0]       acc_wdata,
  output logic [63:0]       acc_rdata,
  output logic              acc_hit,
  output logic              acc_err,
  output logic              acc_done,
  output logic              cell_req,
  output logic              cell_wr,
  output logic [$clog2(NFIFO+NSEM)-1:0] cell_sel,
  output logic [3:0]        cell_view,
  output logic [63:0]       cell_wdata,
  input  logic [63:0]       cell_rdata,
  input  logic              cell_stall
);
  localparam int NCELL  = NFIFO + NSEM;
  localparam int CELL_W = $clog2(NCELL);
  localparam logic [63:0] NCELL64 = 64'(NCELL);

  logic [21:0] base_q;
  logic        en_q;
  logic [6:0]  mask_q;
  logic [2:0]  grain_q;
  logic [17:0] size_q;
  logic        axi_q;
  logic [2:0]  igr_q;

  wire wr0 = cfg_wr && cfg_idx == 3'd0;
  wire wr1 = cfg_wr && cfg_idx == 3'd1;

  wire [6:0]  mask_n   = wr1 ? cfg_wdata[16:10] : mask_q;
  wire [17:0] size_c   = 18'd1024 + {1'b0, mask_n, 10'd0};
  wire        size_pow2 = (size_c & (size_c - 18'd1)) == 18'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      en_q    <= 1'b0;
      mask_q  <= 7'd3;
      grain_q <= 3'd0;
      size_q  <= 18'd4096;
    end else begin
      if (wr0) begin
        base_q <= cfg_wdata[31:10];
        en_q   <= cfg_wdata[0];
      end
      if (wr1) begin
        mask_q  <= cfg_wdata[16:10];
        grain_q <= cfg_wdata[2:0];
      end
      if ((wr0 || wr1) && size_pow2) size_q <= size_c;
    end
  end

  wire [63:0] word0 = {32'd0, base_q, 9'd0, en_q};
  wire [63:0] word1 = (NCELL64 << 20) | {47'd0, mask_q, 7'd0, grain_q};

  always_comb begin
    case (cfg_idx)
      3'd0:    cfg_rdata = word0;
      3'd1:    cfg_rdata = word1;
      default: cfg_rdata = '0;
    endcase
  end

  assign win_base = {base_q, 10'd0};
  assign win_size = size_q;
  assign win_en   = en_q;

  wire [31:0] off     = acc_addr - win_base;
  assign acc_hit      = acc_valid && en_q && acc_addr >= win_base && off < {14'd0, size_q};
  wire        subword = acc_size < 2'd2;
  wire        full    = acc_hit && !subword;
  wire [3:0]  view    = off[6:3];
  wire        to_cell = view <= 4'd5;
  wire        to_icr  = view == 4'd15;

  wire [3:0]  shamt   = 4'd7 + {1'b0, grain_q};
  wire [16:0] idx_raw = off[16:0] >> shamt;
  assign cell_sel = (idx_raw >= 17'(NCELL)) ? CELL_W'(NCELL - 1) : idx_raw[CELL_W-1:0];

  assign cell_view  = view;
  assign cell_req   = full && to_cell;
  assign cell_wr    = acc_wr;
  assign cell_wdata = acc_wdata;
  assign acc_err    = acc_hit && subword;
  assign acc_done   = acc_valid && !(cell_req && cell_stall);

  wire [63:0] icr0 = (NCELL64 << 16) | {53'd0, igr_q, 5'd0, axi_q, 2'd0};

  always_comb begin
    if (!full)        acc_rdata = '0;
    else if (to_cell) acc_rdata = cell_rdata;
    else if (to_icr)  acc_rdata = icr0;
    else              acc_rdata = '1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      axi_q <= 1'b0;
      igr_q <= 3'd0;
    end else if (acc_err) begin
      axi_q <= 1'b1;
    end else if (full && to_icr && acc_wr) begin
      if (acc_wdata[2]) axi_q <= 1'b0;
      igr_q <= acc_wdata[10:8];
    end
  end

  logic unused_bits;
  assign unused_bits = ^{cfg_wdata[63:32], cfg_wdata[9:3], off[31:17]};

  p_size_pow2_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(win_size) == 1);

  p_sel_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cell_req |-> int'(cell_sel) < NCELL);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |=> axi_q);

  p_err_no_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> !cell_req);

  p_miss_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_hit |-> !cell_req && !acc_err);

  p_icr_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_hit && acc_size[1] && acc_wr && cell_view == 4'd15 && acc_wdata[2]) |=> !axi_q);

  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_req && cell_stall) |-> !acc_done);
endmodule

// File: tb/sync_window_decoder_bench.sv
module sync_window_decoder_bench;
  localparam int NFIFO = 16;
  localparam int NSEM  = 16;
  localparam int NCELL = NFIFO + NSEM;
  localparam int CW    = $clog2(NCELL);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cfg_wr = 0;
  logic [2:0]  cfg_idx = 0;
  logic [63:0] cfg_wdata = 0;
  logic [63:0] cfg_rdata;
  logic [31:0] win_base;
  logic [17:0] win_size;
  logic        win_en;
  logic        acc_valid = 0, acc_wr = 0, cell_stall = 0;
  logic [1:0]  acc_size = 0;
  logic [31:0] acc_addr = 0;
  logic [63:0] acc_wdata = 0, cell_rdata = 0;
  logic [63:0] acc_rdata, cell_wdata;
  logic        acc_hit, acc_err, acc_done, cell_req, cell_wr;
  logic [CW-1:0] cell_sel;
  logic [3:0]  cell_view;

  sync_window_decoder #(.NFIFO(NFIFO), .NSEM(NSEM)) u_sync_window_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .win_base(win_base), .win_size(win_size), .win_en(win_en),
    .acc_valid(acc_valid), .acc_wr(acc_wr), .acc_size(acc_size), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_hit(acc_hit), .acc_err(acc_err),
    .acc_done(acc_done), .cell_req(cell_req), .cell_wr(cell_wr), .cell_sel(cell_sel),
    .cell_view(cell_view), .cell_wdata(cell_wdata), .cell_rdata(cell_rdata),
    .cell_stall(cell_stall));

  int checks = 0, fails = 0;
  longint m_base = 0, m_size = 4096;
  bit m_en = 0, m_axi = 0;
  int m_mask = 3, m_grain = 0, m_igr = 0;

  function automatic longint m_word0();
    return m_base | longint'(m_en);
  endfunction
  function automatic longint m_word1();
    return (longint'(NCELL) << 20) | (longint'(m_mask) << 10) | longint'(m_grain);
  endfunction
  function automatic longint m_icr();
    return (longint'(NCELL) << 16) | (longint'(m_igr) << 8) | (longint'(m_axi) << 2);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input int idx, input longint data);
    @(negedge clk);
    cfg_wr = 1; cfg_idx = 3'(idx); cfg_wdata = data;
    @(posedge clk); #1;
    cfg_wr = 0;
    if (idx == 0) begin
      m_base = data & 64'hFFFF_FC00; m_en = data[0];
    end else if (idx == 1) begin
      m_mask = int'((data >> 10) & 7'h7F); m_grain = int'(data & 3'h7);
    end
    if (idx <= 1) begin
      longint cand = 1024 + longint'(m_mask) * 1024;
      if ((cand & (cand - 1)) == 0) m_size = cand;
    end
  endtask

  task automatic cfg_check(input int idx, input string req);
    longint e;
    @(negedge clk);
    cfg_idx = 3'(idx); #1;
    e = (idx == 0) ? m_word0() : (idx == 1) ? m_word1() : 0;
    chk(cfg_rdata == e, req, cfg_rdata, e);
  endtask

  task automatic access(input longint addr, input int sz, input bit wr, input longint wd,
                        input bit stall, input longint crd);
    longint off; bit hit, full; int view; longint idx; longint erd;
    @(negedge clk);
    acc_valid = 1; acc_addr = 32'(addr); acc_size = 2'(sz); acc_wr = wr;
    acc_wdata = wd; cell_stall = stall; cell_rdata = crd;
    #2;
    off  = (addr & 64'hFFFF_FFFF) - m_base;
    hit  = m_en && (addr & 64'hFFFF_FFFF) >= m_base && off < m_size;
    full = hit && sz >= 2;
    view = int'((off >> 3) & 15);
    idx  = off >> (7 + m_grain);
    if (idx >= NCELL) idx = NCELL - 1;
    chk(acc_hit == hit, "R6 hit", acc_hit, hit);
    chk(acc_err == (hit && sz < 2), "R8 err", acc_err, hit && sz < 2);
    chk(cell_req == (full && view <= 5), "R11 req", cell_req, full && view <= 5);
    if (full && view <= 5) begin
      chk(cell_view == 4'(view), "R7 view", cell_view, view);
      chk(cell_sel == CW'(idx), "R7 sel", cell_sel, idx);
      chk(cell_wr == wr, "R11 wr", cell_wr, wr);
      chk(acc_done == !stall, "R11 done", acc_done, !stall);
    end else
      chk(acc_done == 1'b1, "R11 done", acc_done, 1);
    if (!full) erd = 0;
    else if (view <= 5) erd = crd;
    else if (view == 15) erd = m_icr();
    else erd = -1;
    chk(acc_rdata == erd, "R9 R10 rdata", acc_rdata, erd);
    @(posedge clk); #1;
    acc_valid = 0; cell_stall = 0;
    if (hit && sz < 2) m_axi = 1;
    else if (full && view == 15 && wr) begin
      if (wd[2]) m_axi = 0;
      m_igr = int'((wd >> 8) & 7);
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    cfg_check(0, "R1 word0");
    cfg_check(1, "R1 word1");
    chk(win_size == 18'd4096, "R1 size", win_size, 4096);
    chk(win_en == 1'b0, "R1 en", win_en, 0);
    access(32'h0, 3, 0, 0, 0, 0);
    // R2 R4 masking and apply
    cfg_write(0, 64'hFFFF_FFFF_FFFF_FFFF);
    cfg_check(0, "R2 word0 mask");
    chk(win_base == 32'hFFFF_FC00, "R4 base", win_base, 32'hFFFF_FC00);
    cfg_write(0, 64'h0000_0000_4000_0201);
    cfg_check(0, "R2 word0");
    chk(win_base == 32'h4000_0000 && win_en, "R4 base en", win_base, 32'h4000_0000);
    cfg_write(1, 64'hFFFF_FFFF_FFF0_0C00);
    cfg_check(1, "R2 word1 preserves count");
    // R5 non-power-of-two ignored, power-of-two applied
    cfg_write(1, 64'h0000_0800);
    chk(win_size == 18'(m_size) && m_size == 4096, "R5 keep", win_size, m_size);
    cfg_write(1, 64'h0000_1C00);
    chk(win_size == 18'd8192, "R5 apply", win_size, 8192);
    // R3 out-of-map
    cfg_check(2, "R3 read idx2");
    cfg_check(7, "R3 read idx7");
    cfg_write(3, 64'hFFFF_FFFF);
    cfg_check(0, "R3 write ignored w0");
    cfg_check(1, "R3 write ignored w1");
    // R6 edges
    access(32'h3FFF_FFFF, 3, 0, 0, 0, 64'h11);
    access(32'h4000_0000, 3, 0, 0, 0, 64'h22);
    access(32'h4000_1FFF, 3, 0, 0, 0, 64'h33);
    access(32'h4000_2000, 3, 0, 0, 0, 64'h44);
    // R8 sub-word, R9 status
    access(32'h4000_0078, 3, 0, 0, 0, 0);
    access(32'h4000_0010, 0, 1, 0, 0, 0);
    access(32'h4000_0078, 2, 0, 0, 0, 0);
    access(32'h4000_0078, 3, 1, 64'h0000_0504, 0, 0);
    access(32'h4000_0078, 3, 0, 0, 0, 0);
    // R10 inert views
    access(32'h4000_0030, 3, 1, 64'h7FF, 0, 0);
    access(32'h4000_0078, 3, 0, 0, 0, 0);
    // R7 clamp with grain
    cfg_write(1, 64'h0001_FC00);
    access(32'h4001_FF80, 3, 0, 0, 0, 64'h55);
    cfg_write(1, 64'h0001_FC03);
    access(32'h4001_0008, 3, 0, 0, 0, 64'h66);
    // R11 stall
    access(32'h4000_0010, 3, 1, 64'hAB, 1, 0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      int r = int'($urandom_range(0, 19));
      if (r == 0) cfg_write(1, {32'h0, $urandom()});
      else if (r == 1) cfg_write(0, {32'h0, 2'b01, 20'($urandom()), 10'h1});
      else begin
        longint a = m_base + longint'($urandom_range(0, 32'(m_size + m_size / 4))) - 16;
        access(a, int'($urandom_range(0, 3)), 1'($urandom()), {$urandom(), $urandom()},
               1'($urandom()), {$urandom(), $urandom()});
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule